// File: doc/BRIEF.md
# ADC Multiplexer Sequencing Controller

This block shares one analog-to-digital converter among a small set of analog inputs. It advances one state for each pulse of a 32768 Hz clock enable. In each multiplexer cycle it steps the input selector through the active channels and starts a conversion on each one. When a conversion ends it issues a raw-data store strobe tagged with the channel index. After the last conversion it spends one extra state in which no conversion starts. The compute-engine launch falls on the state that enters this slot. The reference-chop signal toggles once at the start of every cycle.

A 2-bit channel-count code selects four, three or two channels, and a resolution bit selects a conversion length of two or three states. New settings take effect only at a cycle boundary. The unused code selects four channels and raises an error flag. A rising edge on the alternate-cycle request is held until the next boundary, and exactly one alternate cycle follows.

Top module: `adc_mux_seq`

## Requirements
- R1: Channel-count code 2'b01 selects 4 channels, 2'b10 selects 3 and 2'b11 selects 2. Within a cycle `mux_ch` visits indices 0 up to count-1 in rising order.
- R2: Code 2'b00 behaves as the 4-channel setting, and `cfg_err` is 1 for exactly the cycles that run with it.
- R3: Each conversion lasts 2 enable pulses when `res_hi`=0 and 3 when `res_hi`=1. `mux_ch` holds its value across the whole conversion.
- R4: One cycle spans channels×length+1 enable pulses: 9/7/5 for 4/3/2 channels with `res_hi`=0, and 13/10/7 with `res_hi`=1. This is the spacing between `ce_launch` pulses.
- R5: The extra state follows the last conversion. `ce_launch` pulses together with the store strobe of the last channel, and no `conv_go` appears with it.
- R6: Changes to `chan_code` and `res_hi` made during a cycle have no effect until the next boundary.
- R7: A rising edge on `alt_req` leaves `alt_cyc` unchanged until the next boundary. `alt_cyc` is then 1 for exactly one cycle, whether the request falls on the next clock, stays high, or rises several times within one cycle.
- R8: `vref_chop` toggles once per cycle, on the boundary pulse, which also starts the conversion of channel 0.
- R9: With `tick` low, no strobe pulses and `mux_ch`, `vref_chop`, `alt_cyc` and `store_ch` keep their values.
- R10: After reset all outputs are 0. The first `tick` is a boundary that starts channel 0 with the settings present at that moment.
- R11: `store_vld` is a one-clock pulse at the end of each conversion. `store_ch` carries the index of the channel just converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32768 Hz clock enable, one clock wide |
| chan_code | input | 2 | Channel-count code |
| res_hi | input | 1 | Conversion length: 0 = 2 states, 1 = 3 states |
| alt_req | input | 1 | Alternate-cycle request (rising edge acts) |
| mux_ch | output | CH_W | Selected input channel |
| conv_go | output | 1 | Starts a conversion and its decimation filter |
| store_vld | output | 1 | Raw-data store strobe at conversion end |
| store_ch | output | CH_W | Channel index for the store |
| ce_launch | output | 1 | Compute-program launch, once per cycle |
| vref_chop | output | 1 | Reference chop level |
| alt_cyc | output | 1 | High for the duration of an alternate cycle |
| cfg_err | output | 1 | Current cycle runs with the unused code |

## Verification
The hardest case is an alternate-cycle request whose edge lands mid-cycle and is gone long before the boundary. It is hard in a different way when the request rises twice, or stays high across several boundaries. The bench makes these edges on clocks between enable pulses, at a known position after a launch. It then counts how many cycles report `alt_cyc` at their launch. Settings are also changed a fixed number of pulses into a cycle, and the distance to the next launch is measured, to show that the running cycle keeps its old length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W  = 2;
  localparam int NCH_W = 3;
  localparam int LEN_W = 2;
  localparam int CYC_W = 5;

  typedef struct packed {
    logic [NCH_W-1:0] nch;
    logic [LEN_W-1:0] clen;
    logic             bad;
  } seq_cfg_t;

  function automatic logic [NCH_W-1:0] chan_count(input logic [1:0] code);
    case (code)
      2'b10:   return NCH_W'(3);
      2'b11:   return NCH_W'(2);
      default: return NCH_W'(4);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] conv_len(input logic res);
    return res ? LEN_W'(3) : LEN_W'(2);
  endfunction

  function automatic logic [CYC_W-1:0] cycle_len(input logic [NCH_W-1:0] nch,
                                                 input logic [LEN_W-1:0] clen);
    logic [CYC_W-1:0] a;
    logic [CYC_W-1:0] b;
    a = CYC_W'(nch);
    b = CYC_W'(clen);
    return a * b + CYC_W'(1);
  endfunction

  function automatic seq_cfg_t decode_cfg(input logic [1:0] code, input logic res);
    seq_cfg_t c;
    c.nch  = chan_count(code);
    c.clen = conv_len(res);
    c.bad  = (code == 2'b00);
    return c;
  endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bnd,
  input  logic [1:0] code,
  input  logic       res,
  output seq_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= decode_cfg(2'b01, 1'b0);
    end else if (bnd) begin
      cfg <= decode_cfg(code, res);
    end
  end
endmodule

// File: rtl/adc_seq_alt.sv
module adc_seq_alt (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_req,
  input  logic bnd,
  output logic alt_cyc
);
  logic req_q;
  logic pend;
  logic rise;

  assign rise = alt_req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pend    <= 1'b0;
      alt_cyc <= 1'b0;
    end else begin
      req_q <= alt_req;
      if (bnd) begin
        alt_cyc <= pend | rise;
        pend    <= 1'b0;
      end else if (rise) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_slot.sv
module adc_seq_slot
  import adc_seq_pkg::*;
#(
  parameter int CHW = CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCH_W-1:0] nch,
  input  logic [LEN_W-1:0] clen,
  output logic [CHW-1:0]   ch,
  output logic             bnd,
  output logic             ev_conv,
  output logic             ev_store,
  output logic             ev_last
);
  logic [LEN_W-1:0] ph;
  logic             idle;
  logic             ph_end;
  logic             ch_end;

  assign ph_end   = (ph == clen - LEN_W'(1));
  assign ch_end   = (NCH_W'(ch) == nch - NCH_W'(1));
  assign bnd      = tick & idle;
  assign ev_conv  = tick & (idle | (ph_end & ~ch_end));
  assign ev_store = tick & ~idle & ph_end;
  assign ev_last  = ev_store & ch_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch   <= '0;
      ph   <= '0;
      idle <= 1'b1;
    end else if (tick) begin
      if (idle) begin
        ch   <= '0;
        ph   <= '0;
        idle <= 1'b0;
      end else if (ph_end) begin
        ph <= '0;
        if (ch_end) idle <= 1'b1;
        else        ch   <= ch + CHW'(1);
      end else begin
        ph <= ph + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W = adc_seq_pkg::CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      chan_code,
  input  logic            res_hi,
  input  logic            alt_req,
  output logic [CH_W-1:0] mux_ch,
  output logic            conv_go,
  output logic            store_vld,
  output logic [CH_W-1:0] store_ch,
  output logic            ce_launch,
  output logic            vref_chop,
  output logic            alt_cyc,
  output logic            cfg_err
);
  seq_cfg_t         act_cfg;
  logic [NCH_W-1:0] act_nch;
  logic [LEN_W-1:0] act_clen;
  logic             bnd;
  logic             ev_conv;
  logic             ev_store;
  logic             ev_last;
  logic [CH_W-1:0]  cur_ch;

  assign act_nch  = act_cfg.nch;
  assign act_clen = act_cfg.clen;
  assign cfg_err  = act_cfg.bad;
  assign mux_ch   = cur_ch;

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .bnd(bnd),
    .code(chan_code), .res(res_hi), .cfg(act_cfg)
  );

  adc_seq_slot #(.CHW(CH_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .nch(act_nch), .clen(act_clen), .ch(cur_ch), .bnd(bnd),
    .ev_conv(ev_conv), .ev_store(ev_store), .ev_last(ev_last)
  );

  adc_seq_alt u_alt (
    .clk(clk), .rst_n(rst_n), .alt_req(alt_req),
    .bnd(bnd), .alt_cyc(alt_cyc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_go   <= 1'b0;
      store_vld <= 1'b0;
      store_ch  <= '0;
      ce_launch <= 1'b0;
      vref_chop <= 1'b0;
    end else begin
      conv_go   <= ev_conv;
      store_vld <= ev_store;
      ce_launch <= ev_last;
      if (ev_store) store_ch  <= cur_ch;
      if (bnd)      vref_chop <= ~vref_chop;
    end
  end
endmodule

// File: rtl/adc_mux_seq_chk.sv
module adc_mux_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CH_W = adc_seq_pkg::CH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CH_W-1:0]  mux_ch,
  input logic             conv_go,
  input logic             store_vld,
  input logic [CH_W-1:0]  store_ch,
  input logic             ce_launch,
  input logic             vref_chop,
  input logic             alt_cyc,
  input logic             cfg_err,
  input logic [NCH_W-1:0] act_nch,
  input logic [LEN_W-1:0] act_clen
);
  logic [CYC_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         tick_cnt <= '0;
    else if (ce_launch) tick_cnt <= tick ? CYC_W'(1) : CYC_W'(0);
    else if (tick)      tick_cnt <= tick_cnt + CYC_W'(1);
  end

  a_r4_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
    ce_launch |-> tick_cnt == cycle_len(act_nch, act_clen));

  a_r9_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go | store_vld | ce_launch) |-> $past(tick));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(mux_ch) && $stable(vref_chop) && $stable(alt_cyc)));

  a_r8_chop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vref_chop) |-> (conv_go && mux_ch == '0));

  a_r7_alt_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_cyc) |-> !$stable(vref_chop));

  a_r5_launch_last: assert property (@(posedge clk) disable iff (!rst_n)
    ce_launch |-> (store_vld && !conv_go && NCH_W'(store_ch) == act_nch - NCH_W'(1)));

  a_r11_store_tag: assert property (@(posedge clk) disable iff (!rst_n)
    store_vld |-> store_ch == $past(mux_ch));

  a_r2_err_four: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> act_nch == NCH_W'(4));

  a_r1_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
    NCH_W'(mux_ch) < act_nch);
endmodule

bind adc_mux_seq adc_mux_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mux_ch(mux_ch),
  .conv_go(conv_go), .store_vld(store_vld), .store_ch(store_ch),
  .ce_launch(ce_launch), .vref_chop(vref_chop), .alt_cyc(alt_cyc),
  .cfg_err(cfg_err), .act_nch(act_nch), .act_clen(act_clen)
);

// File: tb/sim_adc_mux_seq.sv
module sim_adc_mux_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] code = 2'b01;
  logic       res = 1'b0;
  logic       alt_req = 1'b0;
  logic [1:0] mux_ch;
  logic       conv_go;
  logic       store_vld;
  logic [1:0] store_ch;
  logic       ce_launch;
  logic       vref_chop;
  logic       alt_cyc;
  logic       cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int m_t = -1;
  int m_nch = 4;
  int m_len = 2;
  int m_tag = 0;
  bit m_chop = 0;
  bit m_alt = 0;
  bit m_pend = 0;
  bit m_err = 0;
  int since_launch = 0;
  int last_gap = 0;

  always #5 clk = ~clk;

  adc_mux_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_code(code), .res_hi(res),
    .alt_req(alt_req), .mux_ch(mux_ch), .conv_go(conv_go), .store_vld(store_vld),
    .store_ch(store_ch), .ce_launch(ce_launch), .vref_chop(vref_chop),
    .alt_cyc(alt_cyc), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one enable pulse; the reference model steps by slot index
  task automatic do_tick();
    int span;
    logic [9:0] e;
    logic [9:0] a;
    bit e_conv, e_store, e_launch;
    int e_mux;
    if (m_t < 0 || m_t == m_nch * m_len) begin
      m_nch  = (code == 2'b10) ? 3 : (code == 2'b11) ? 2 : 4;
      m_len  = res ? 3 : 2;
      m_err  = (code == 2'b00);
      m_t    = 0;
      m_chop = !m_chop;
      m_alt  = m_pend;
      m_pend = 0;
    end else begin
      m_t++;
    end
    span     = m_nch * m_len;
    e_conv   = (m_t < span) && (m_t % m_len == 0);
    e_store  = (m_t > 0) && (m_t <= span) && (m_t % m_len == 0);
    if (e_store) m_tag = m_t / m_len - 1;
    e_launch = (m_t == span);
    e_mux    = (m_t < span) ? m_t / m_len : m_nch - 1;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    e = {e_conv, e_store, 2'(m_tag), e_launch, 2'(e_mux), m_chop, m_alt, m_err};
    a = {conv_go, store_vld, store_ch, ce_launch, mux_ch, vref_chop, alt_cyc, cfg_err};
    chk("R1 R2 R3 R5 R7 R8 R11 slot sequence", 32'(a), 32'(e));
    since_launch++;
    if (ce_launch) begin
      last_gap = since_launch;
      since_launch = 0;
    end
  endtask

  task automatic run_to_launch(output int n);
    n = 0;
    do begin
      do_tick();
      n++;
    end while (!ce_launch && n < 40);
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", 32'({mux_ch, conv_go, store_vld, store_ch, ce_launch,
        vref_chop, alt_cyc, cfg_err}), 32'd0);
    do_tick();
    chk("R10 first tick starts ch0", 32'({conv_go, mux_ch}), 32'b100);
  endtask

  task automatic t_modes();
    int exp_len [6] = '{9, 7, 5, 13, 10, 7};
    for (int r = 0; r < 2; r++) begin
      for (int c = 1; c < 4; c++) begin
        code = 2'(c);
        res  = r[0];
        repeat (30) do_tick();
        chk("R4 cycle length", 32'(last_gap), 32'(exp_len[r * 3 + c - 1]));
      end
    end
  endtask

  task automatic t_latch();
    int n;
    code = 2'b01; res = 1'b1;
    run_to_launch(n);
    run_to_launch(n);
    do_tick(); do_tick(); do_tick();
    code = 2'b11; res = 1'b0;
    run_to_launch(n);
    chk("R6 running cycle keeps length", 32'(n), 32'd10);
    run_to_launch(n);
    chk("R6 new length after boundary", 32'(n), 32'd5);
  endtask

  task automatic t_code00();
    int n;
    code = 2'b00; res = 1'b0;
    run_to_launch(n);
    run_to_launch(n);
    chk("R2 code 00 runs 4 channels", 32'(n), 32'd9);
    chk("R2 error flag set", 32'(cfg_err), 32'd1);
    code = 2'b01;
    run_to_launch(n);
    run_to_launch(n);
    chk("R2 error flag clears", 32'(cfg_err), 32'd0);
  endtask

  task automatic pulse_alt(int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk) alt_req = 1'b1;
      m_pend = 1;
      @(negedge clk) alt_req = 1'b0;
    end
  endtask

  task automatic count_alt(string req, int cycles);
    int n;
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      run_to_launch(n);
      if (alt_cyc) hits++;
    end
    chk(req, 32'(hits), 32'd1);
  endtask

  task automatic t_alt();
    int n;
    code = 2'b10; res = 1'b0;
    run_to_launch(n);
    do_tick(); do_tick();
    pulse_alt(1);
    chk("R7 alt deferred", 32'(alt_cyc), 32'd0);
    count_alt("R7 one alt cycle after short pulse", 3);
    do_tick(); do_tick();
    @(negedge clk) alt_req = 1'b1;
    m_pend = 1;
    count_alt("R7 one alt cycle while held", 3);
    @(negedge clk) alt_req = 1'b0;
    do_tick();
    pulse_alt(2);
    count_alt("R7 one alt cycle for two rises", 3);
  endtask

  task automatic t_notick();
    logic [5:0] held;
    held = {mux_ch, store_ch, vref_chop, alt_cyc};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9 no strobe without tick", 32'({conv_go, store_vld, ce_launch}), 32'd0);
    end
    chk("R9 state held without tick", 32'({mux_ch, store_ch, vref_chop, alt_cyc}), 32'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_latch();
    t_code00();
    do_tick(); do_tick();
    t_notick();
    t_alt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule